// File: doc/BRIEF.md
# Repeated-Application Delay Test Sequencer

This block lets a slow tester measure path delays at the rated clock of a sequential circuit under test. It accepts test vectors over a valid/ready stream, drives each one onto the circuit's primary inputs and applies it `REP_N` times in a row. `REP_N` is the ratio of the rated clock frequency to the tester's application rate. During every application the circuit's flip-flops get clock enables at the full rated rate. The response is sampled at a point that moves one rated cycle later with each new application. Across the `REP_N` applications the slow tester therefore sees the circuit's outputs at every rated-cycle position after launch. The price is total test time of `REP_N` squared times that of an at-speed tester.

Each application takes one slot of `REP_N + 1` fast cycles. The first cycle of a slot is the launch cycle, and the flip-flop enable stays low in it. The next `REP_N` cycles are sub-slots, each marked by one phase-shifted pin enable, and the OR of those enables forms the rated-clock enable. Application k samples the circuit output in sub-slot k. It then presents the captured word with index k. A sideband flag on the stream marks the final vector, and `done` pulses when that vector's final capture appears. With `REP_N = 1` the block reduces to plain at-speed application with one capture per vector. No hardware is added to the circuit under test, and only the supplied vectors are applied.

Top module: `slowtest_seq`

## Requirements
- R1: After a synchronous active-high reset, `vec_ready` is 1, and `cap_valid`, `done` and `cut_clk_en` are 0. A reset in the middle of a vector aborts it: the block is idle the next cycle and produces no further captures or enables.
- R2: A vector is accepted on a clock edge where `vec_valid` and `vec_ready` are both 1. `cut_pi` shows that vector from the next cycle on and holds it unchanged until the next acceptance.
- R3: `vec_ready` is 0 for exactly `REP_N*(REP_N+1)` cycles after an acceptance, and is 1 again in the cycle after that.
- R4: Each vector is applied `REP_N` times. Each application lasts `REP_N+1` cycles: one launch cycle with `cut_clk_en` at 0, then `REP_N` cycles with `cut_clk_en` at 1. A vector therefore gets exactly `REP_N*REP_N` enable cycles, and no enable occurs while idle.
- R5: In application k (k = 1..`REP_N`), `cut_po` is sampled in the cycle k fast cycles after that application's launch cycle. In the following cycle `cap_valid` is 1 for one cycle, `cap_data` holds the sampled word and `cap_idx` equals k. Captures come in order k = 1..`REP_N`, exactly `REP_N` per vector.
- R6: `done` is a one-cycle pulse in the same cycle as the capture with `cap_idx = REP_N` of a vector accepted with `vec_last = 1`. Vectors accepted with `vec_last = 0` produce no `done`.
- R7: A vector held valid while the previous one finishes is accepted on the edge that ends the previous one's final capture cycle, so back-to-back vectors lose no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated-speed fast clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_data | input | VEC_W | Test vector from the tester |
| vec_last | input | 1 | Marks the final vector of the set |
| vec_valid | input | 1 | Vector available |
| vec_ready | output | 1 | Block can accept a vector |
| cut_pi | output | VEC_W | Primary-input drive to the circuit under test |
| cut_clk_en | output | 1 | Rated-clock enable for the circuit's flip-flops |
| cut_po | input | RSP_W | Circuit output bus |
| cap_data | output | RSP_W | Captured response word |
| cap_idx | output | IDX_W | Application index of the capture (1..REP_N) |
| cap_valid | output | 1 | Capture present, one cycle |
| done | output | 1 | Last application of the last vector finished |

## Verification
The final capture of a vector and the `done` pulse are produced in the same cycle. That cycle is also the one in which `vec_ready` returns and a waiting vector can be accepted. The bench provokes this collision by sending a last-flagged vector and by holding a second vector valid throughout the first. A small counter model of the circuit in the bench tags each response with the number of enable cycles since launch. Each `done` is judged by requiring `cap_valid` with index `REP_N` in the same sampled cycle. The back-to-back case must also yield `2*REP_N` ordered captures whose values match their positions.

// File: rtl/slowtest_pkg.sv
package slowtest_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/slowtest_phase.sv
// Sub-slot timing: phase 0 is the launch cycle, phases 1..REP_N are sub-slots.
module slowtest_phase #(
  parameter int REP_N = 4,
  parameter int PH_W  = $clog2(REP_N + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  output logic [PH_W-1:0] phase,
  output logic            slot_end,
  output logic            rate_en
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(REP_N);

  logic [REP_N-1:0] pin_en;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      phase <= '0;
    end else if (phase == LAST_PH) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // One slow pin enable per sub-slot, each shifted by one fast cycle.
  generate
    for (genvar j = 0; j < REP_N; j++) begin : g_pin
      assign pin_en[j] = run && (phase == PH_W'(j + 1));
    end
  endgenerate

  assign rate_en  = |pin_en;
  assign slot_end = run && (phase == LAST_PH);

  // R4
  phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);
  // R4
  pin_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pin_en));
endmodule

// File: rtl/slowtest_ctrl.sv
// Repetition counter and vector holding register.
module slowtest_ctrl
  import slowtest_pkg::*;
#(
  parameter int REP_N = 4,
  parameter int VEC_W = 8,
  parameter int IDX_W = $clog2(REP_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] vec_data,
  input  logic             vec_last,
  input  logic             vec_valid,
  output logic             vec_ready,
  input  logic             slot_end,
  output logic             run,
  output logic [IDX_W-1:0] app,
  output logic             is_last,
  output logic [VEC_W-1:0] pi_q
);
  localparam logic [IDX_W-1:0] LAST_APP = IDX_W'(REP_N);

  seq_state_t state;
  logic       take;

  assign vec_ready = (state == ST_IDLE);
  assign run       = (state == ST_RUN);
  assign take      = vec_valid && vec_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      app     <= '0;
      is_last <= 1'b0;
      pi_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            state   <= ST_RUN;
            app     <= IDX_W'(1);
            is_last <= vec_last;
            pi_q    <= vec_data;
          end
        end
        ST_RUN: begin
          if (slot_end) begin
            if (app == LAST_APP) begin
              state <= ST_IDLE;
              app   <= '0;
            end else begin
              app <= app + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !vec_ready);
  // R2
  pi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(pi_q));
  // R4
  app_range_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (app >= IDX_W'(1) && app <= LAST_APP));
endmodule

// File: rtl/slowtest_capture.sv
// Output strobe and capture register.
module slowtest_capture #(
  parameter int REP_N = 4,
  parameter int RSP_W = 8,
  parameter int IDX_W = $clog2(REP_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [IDX_W-1:0] app,
  input  logic             is_last,
  input  logic [RSP_W-1:0] cut_po,
  output logic [RSP_W-1:0] cap_data,
  output logic [IDX_W-1:0] cap_idx,
  output logic             cap_valid,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST_APP = IDX_W'(REP_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_data  <= '0;
      cap_idx   <= '0;
      cap_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      cap_valid <= strobe;
      done      <= strobe && is_last && (app == LAST_APP);
      if (strobe) begin
        cap_data <= cut_po;
        cap_idx  <= app;
      end
    end
  end

  // R5
  cap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cap_valid && cap_idx != LAST_APP |=> !cap_valid);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/slowtest_seq.sv
module slowtest_seq #(
  parameter int REP_N = 4,
  parameter int VEC_W = 8,
  parameter int RSP_W = 8,
  parameter int IDX_W = $clog2(REP_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VEC_W-1:0] vec_data,
  input  logic             vec_last,
  input  logic             vec_valid,
  output logic             vec_ready,
  output logic [VEC_W-1:0] cut_pi,
  output logic             cut_clk_en,
  input  logic [RSP_W-1:0] cut_po,
  output logic [RSP_W-1:0] cap_data,
  output logic [IDX_W-1:0] cap_idx,
  output logic             cap_valid,
  output logic             done
);
  localparam int PH_W = IDX_W;

  logic            run;
  logic            slot_end;
  logic            rate_en;
  logic            is_last;
  logic            strobe;
  logic [PH_W-1:0] phase;
  logic [IDX_W-1:0] app;

  slowtest_phase #(.REP_N(REP_N), .PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .phase    (phase),
    .slot_end (slot_end),
    .rate_en  (rate_en)
  );

  slowtest_ctrl #(.REP_N(REP_N), .VEC_W(VEC_W), .IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .vec_data  (vec_data),
    .vec_last  (vec_last),
    .vec_valid (vec_valid),
    .vec_ready (vec_ready),
    .slot_end  (slot_end),
    .run       (run),
    .app       (app),
    .is_last   (is_last),
    .pi_q      (cut_pi)
  );

  // Application k samples in sub-slot k, i.e. k cycles after launch.
  assign strobe     = run && (phase == app);
  assign cut_clk_en = rate_en;

  slowtest_capture #(.REP_N(REP_N), .RSP_W(RSP_W), .IDX_W(IDX_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .app       (app),
    .is_last   (is_last),
    .cut_po    (cut_po),
    .cap_data  (cap_data),
    .cap_idx   (cap_idx),
    .cap_valid (cap_valid),
    .done      (done)
  );

  // R6
  done_with_cap_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cap_valid && cap_idx == IDX_W'(REP_N)));
  // R5
  cap_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    cap_valid |-> (cap_idx >= IDX_W'(1) && cap_idx <= IDX_W'(REP_N)));
  // R4
  idle_no_en_chk: assert property (@(posedge clk) disable iff (rst)
    vec_ready |-> !cut_clk_en);
endmodule

// File: tb/slowtest_seq_tb.sv
module slowtest_seq_tb_top;
  localparam int N     = 4;
  localparam int VW    = 8;
  localparam int RW    = 8;
  localparam int IW    = $clog2(N + 1);
  localparam int SPAN  = N * (N + 1);
  localparam int WDOG  = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [VW-1:0] vec_data = '0;
  logic          vec_last = 1'b0;
  logic          vec_valid = 1'b0;
  logic          vec_ready;
  logic [VW-1:0] cut_pi;
  logic          cut_clk_en;
  logic [RW-1:0] cut_po;
  logic [RW-1:0] cap_data;
  logic [IW-1:0] cap_idx;
  logic          cap_valid;
  logic          done;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  slowtest_seq #(.REP_N(N), .VEC_W(VW), .RSP_W(RW)) dut_i (
    .clk(clk), .rst(rst), .vec_data(vec_data), .vec_last(vec_last),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .cut_pi(cut_pi),
    .cut_clk_en(cut_clk_en), .cut_po(cut_po), .cap_data(cap_data),
    .cap_idx(cap_idx), .cap_valid(cap_valid), .done(done)
  );

  // Circuit model: counts enabled edges since the last launch cycle.
  logic [RW-1:0] cut_cnt = '0;
  always @(posedge clk) begin
    if (!cut_clk_en) cut_cnt <= '0;
    else             cut_cnt <= cut_cnt + 1'b1;
  end
  assign cut_po = cut_pi ^ cut_cnt;

  // Monitor, sampled at the falling edge.
  int            cap_n = 0;
  int            en_n = 0;
  int            done_n = 0;
  int            done_bad = 0;
  int            rdy_low_n = 0;
  int            pi_chg_n = 0;
  int            cap_i_a [0:63];
  int            cap_d_a [0:63];
  logic [VW-1:0] pi_prev = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (cap_valid) begin
        if (cap_n < 64) begin
          cap_i_a[cap_n] = int'(cap_idx);
          cap_d_a[cap_n] = int'(cap_data);
        end
        cap_n++;
      end
      if (cut_clk_en) en_n++;
      if (!vec_ready) rdy_low_n++;
      if (done) begin
        done_n++;
        if (!(cap_valid && int'(cap_idx) == N)) done_bad++;
      end
      if (cut_pi != pi_prev) pi_chg_n++;
    end
    pi_prev = cut_pi;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);
    check(vec_ready == 1'b1, "R1 ready", int'(vec_ready), 1);
    check(cap_valid == 1'b0, "R1 cap_valid", int'(cap_valid), 0);
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(cut_clk_en == 1'b0, "R1 clk_en", int'(cut_clk_en), 0);
  endtask

  task automatic t_idle();
    int e0 = en_n;
    int c0 = cap_n;
    wait_cyc(10);
    check(en_n == e0, "R4 idle enables", en_n - e0, 0);
    check(cap_n == c0, "R5 idle captures", cap_n - c0, 0);
  endtask

  // Apply one vector and check captures, enables, ready and done.
  task automatic t_vector(input logic [VW-1:0] v, input bit last);
    int c0 = cap_n;
    int e0 = en_n;
    int d0 = done_n;
    int r0 = rdy_low_n;
    int p0 = pi_chg_n;
    vec_data  = v;
    vec_last  = last;
    vec_valid = 1'b1;
    wait_cyc(1);
    vec_valid = 1'b0;
    check(cut_pi == v, "R2 cut_pi", int'(cut_pi), int'(v));
    wait_cyc(SPAN + 1);
    check(cap_n - c0 == N, "R5 capture count", cap_n - c0, N);
    for (int k = 1; k <= N; k++) begin
      check(cap_i_a[c0 + k - 1] == k, "R5 index order", cap_i_a[c0 + k - 1], k);
      check(cap_d_a[c0 + k - 1] == int'(v ^ VW'(k - 1)), "R5 strobe position",
            cap_d_a[c0 + k - 1], int'(v ^ VW'(k - 1)));
    end
    check(en_n - e0 == N * N, "R4 enable cycles", en_n - e0, N * N);
    check(rdy_low_n - r0 == SPAN, "R3 busy span", rdy_low_n - r0, SPAN);
    check(vec_ready == 1'b1, "R3 ready back", int'(vec_ready), 1);
    check(pi_chg_n - p0 == 1, "R2 cut_pi hold", pi_chg_n - p0, 1);
    check(done_n - d0 == (last ? 1 : 0), "R6 done count", done_n - d0, last ? 1 : 0);
    check(done_bad == 0, "R6 done with final capture", done_bad, 0);
  endtask

  task automatic t_back_to_back(input logic [VW-1:0] a, input logic [VW-1:0] b);
    int c0 = cap_n;
    int d0 = done_n;
    vec_data  = a;
    vec_last  = 1'b0;
    vec_valid = 1'b1;
    wait_cyc(1);
    vec_data  = b;
    vec_last  = 1'b1;
    wait_cyc(SPAN + 1);
    vec_valid = 1'b0;
    check(cut_pi == b, "R7 second accepted without gap", int'(cut_pi), int'(b));
    wait_cyc(SPAN + 1);
    check(cap_n - c0 == 2 * N, "R7 capture count", cap_n - c0, 2 * N);
    for (int k = 1; k <= N; k++) begin
      check(cap_d_a[c0 + k - 1] == int'(a ^ VW'(k - 1)), "R7 first vector data",
            cap_d_a[c0 + k - 1], int'(a ^ VW'(k - 1)));
      check(cap_d_a[c0 + N + k - 1] == int'(b ^ VW'(k - 1)), "R7 second vector data",
            cap_d_a[c0 + N + k - 1], int'(b ^ VW'(k - 1)));
    end
    check(done_n - d0 == 1, "R6 single done", done_n - d0, 1);
    check(done_bad == 0, "R6 done aligned", done_bad, 0);
  endtask

  task automatic t_abort();
    int c0;
    int e0;
    vec_data  = 8'h3C;
    vec_last  = 1'b1;
    vec_valid = 1'b1;
    wait_cyc(1);
    vec_valid = 1'b0;
    wait_cyc(7);
    rst = 1'b1;
    wait_cyc(1);
    rst = 1'b0;
    check(vec_ready == 1'b1, "R1 abort ready", int'(vec_ready), 1);
    check(cut_clk_en == 1'b0, "R1 abort clk_en", int'(cut_clk_en), 0);
    c0 = cap_n;
    e0 = en_n;
    wait_cyc(SPAN + 5);
    check(cap_n == c0, "R1 abort no captures", cap_n - c0, 0);
    check(en_n == e0, "R1 abort no enables", en_n - e0, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_vector(8'hA5, 1'b0);
    t_vector(8'h5A, 1'b1);
    t_vector(8'hF0, 1'b1);
    t_back_to_back(8'h81, 8'h7E);
    t_abort();
    t_vector(8'h96, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule